// File: doc/BRIEF.md
# Dual-Phase Harmonic Demodulator

This block is the detection stage of a digital lock-in receiver. It takes signed ADC samples, one per valid strobe, and multiplies each sample by two reference sinusoids that it generates itself. The two references are a quarter turn apart. The results are an in-phase product stream (X) and a quadrature product stream (Y). Low-pass filtering of the products happens downstream and is not part of this block.

A 32-bit fundamental phase accumulator advances by a programmable frequency word on every sample. The references are not taken at the fundamental. They run at a programmable integer harmonic N of it, plus a programmable 32-bit phase offset, which gives steps well under a microdegree. A second accumulator holds N times the fundamental phase, so no multiply is needed on each sample. A third sine output always follows the fundamental, whatever N and the offset are.

Settings are written through a small write port and are staged in shadow registers. They reach the datapath at the next sample boundary. A harmonic that is out of range, or that would place the reference above one quarter of the sample rate, is refused and flagged. Sine values come from a computed quarter-wave table with 256 points per turn.

Top module: `harm_demod`

## Requirements
- R1: While reset is applied, and until the first sample after reset, out_valid, out_x, out_y, ref_sine and harm_rej are all 0. The active settings after reset are frequency 0, harmonic 1 and offset 0.
- R2: The fundamental phase F starts at 0 and grows by the active frequency word, modulo 2^32, at each sample. ref_sine equals S(F), where S(p) = round(32767·sin(2π·p[31:24]/256)), rounded half away from zero.
- R3: out_x equals sample × S(N·F + θ) modulo 2^32, as a 32-bit signed product. N is the active harmonic and θ is the active offset.
- R4: out_y equals sample × S(N·F + θ + 2^30), which is the X reference advanced by exactly 90 degrees. Consequently the squares of the two reference values always sum to 32767² within 2·32767.
- R5: out_valid is a one-cycle pulse in the third cycle after the cycle in which in_valid was high. The product and sine outputs are updated in that same cycle.
- R6: A harmonic write (cfg_sel = 1, N in cfg_wdata[6:0]) is accepted only if 1 ≤ N ≤ 99 and N × (latest written frequency word) ≤ 2^30. A refused write sets harm_rej to 1 and keeps the previous N. An accepted write clears harm_rej.
- R7: Writes to frequency (cfg_sel = 0), harmonic and offset (cfg_sel = 2) do not affect the sample in progress or the next sample. The sample after a write still uses the old settings. The new settings govern the phase step taken at that sample and every later sample. The phases do not move on cycles without a sample.
- R8: ref_sine depends only on the frequency history. Changing N or θ does not alter it.
- R9: When new settings are applied, the harmonic phase is set to N_new × F rather than continuing from its old value, so the references stay phase-synchronous with the fundamental.
- R10: A write with cfg_sel = 3 has no effect on any setting or on harm_rej.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed ADC sample |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting select: 0 frequency, 1 harmonic, 2 phase offset, 3 none |
| cfg_wdata | input | 32 | Setting value |
| harm_rej | output | 1 | Last harmonic write was refused |
| out_valid | output | 1 | Product outputs valid |
| out_x | output | 32 | In-phase product, signed |
| out_y | output | 32 | Quadrature product, signed |
| ref_sine | output | 16 | Fundamental sine value, signed |

## Verification
The hardest case to reach from the ports is the harmonic resynchronisation. It only shows up when N changes after the fundamental phase has built up a value that is not a multiple of 2^32/N. The stimulus therefore runs several samples at an odd frequency word first and then changes N. A bench model computes N·F directly, so any drift between the two accumulators shows up in X and Y. The acceptance limit is tested exactly at N × frequency = 2^30 and one step above it. Samples taken right after each write confirm that the old settings still apply to the first sample and the new ones to the samples after it.

// File: rtl/harm_demod_pkg.sv
package harm_demod_pkg;

  // setting select codes on the write port
  typedef enum logic [1:0] {
    CFG_FREQ  = 2'd0,
    CFG_HARM  = 2'd1,
    CFG_PHASE = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  localparam int HARM_W   = 7;
  localparam int HARM_MAX = 99;

endpackage

// File: rtl/hd_sine_lut.sv
// Quarter-wave sine lookup: the quadrant comes from the top two index bits,
// the table holds Q+1 points from 0 to 90 degrees inclusive.
module hd_sine_lut #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic [AW+1:0]        pidx,
  output logic signed [DW-1:0] value
);

  localparam int  Q   = 1 << AW;
  localparam int  AMP = (1 << (DW - 1)) - 1;
  localparam real PI  = 3.14159265358979323846;

  logic [DW-1:0] tbl [0:Q];

  for (genvar g = 0; g <= Q; g++) begin : g_tbl
    localparam real ANG = PI * real'(g) / (2.0 * real'(Q));
    localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
    assign tbl[g] = VAL[DW-1:0];
  end

  logic [1:0]    quad;
  logic [AW-1:0] idx;
  logic [AW:0]   addr;
  logic [DW-1:0] mag;

  always_comb begin
    quad  = pidx[AW+1:AW];
    idx   = pidx[AW-1:0];
    addr  = quad[0] ? ((AW+1)'(Q) - {1'b0, idx}) : {1'b0, idx};
    mag   = tbl[addr];
    value = quad[1] ? -$signed(mag) : $signed(mag);
  end

endmodule

// File: rtl/hd_phase_gen.sv
// Fundamental and harmonic phase accumulators with staged settings.
module hd_phase_gen
  import harm_demod_pkg::*;
#(
  parameter int PW   = 32,
  parameter int HW   = HARM_W,
  parameter int HMAX = HARM_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [PW-1:0] cfg_wdata,
  output logic [PW-1:0] fund_ph,
  output logic [PW-1:0] harm_ph,
  output logic [PW-1:0] ofs_ph,
  output logic          harm_rej
);

  localparam int PAD = PW - HW;
  localparam logic [2*PW-1:0] LIMIT = {{(2*PW-1){1'b0}}, 1'b1} << (PW - 2);

  // shadow (written) and active (in use) settings
  logic [PW-1:0] sh_freq, sh_freq_d, sh_th, sh_th_d;
  logic [HW-1:0] sh_n, sh_n_d;
  logic [PW-1:0] act_freq, act_freq_d, act_th, act_th_d;
  logic [HW-1:0] act_n, act_n_d;
  logic          pend, pend_d, rej_q, rej_d;
  logic [PW-1:0] hstep, hstep_d, f_q, f_d, h_q, h_d;

  logic              wr_freq, wr_harm, wr_phase, harm_ok;
  logic [HW-1:0]     cand;
  logic [2*PW-1:0]   cand_prod;
  logic [PW-1:0]     sh_n_ext;

  always_comb begin
    wr_freq   = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_FREQ);
    wr_harm   = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_HARM);
    wr_phase  = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_PHASE);
    cand      = cfg_wdata[HW-1:0];
    cand_prod = {{PW{1'b0}}, {{PAD{1'b0}}, cand}} * {{PW{1'b0}}, sh_freq};
    harm_ok   = (cand != '0) && (cand <= HW'(HMAX)) && (cand_prod <= LIMIT);
    sh_n_ext  = {{PAD{1'b0}}, sh_n};
  end

  // next-state logic
  always_comb begin
    sh_freq_d  = wr_freq  ? cfg_wdata : sh_freq;
    sh_th_d    = wr_phase ? cfg_wdata : sh_th;
    sh_n_d     = (wr_harm && harm_ok) ? cand : sh_n;
    rej_d      = wr_harm ? !harm_ok : rej_q;
    pend_d     = pend;
    act_freq_d = act_freq;
    act_th_d   = act_th;
    act_n_d    = act_n;
    hstep_d    = hstep;
    f_d        = f_q;
    h_d        = h_q;
    if (smp_en) begin
      pend_d = 1'b0;
      if (pend) begin
        act_freq_d = sh_freq;
        act_th_d   = sh_th;
        act_n_d    = sh_n;
        f_d        = f_q + sh_freq;
        h_d        = sh_n_ext * f_d;
        hstep_d    = sh_n_ext * sh_freq;
      end else begin
        f_d = f_q + act_freq;
        h_d = h_q + hstep;
      end
    end
    if (wr_freq || wr_phase || (wr_harm && harm_ok)) pend_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_freq  <= '0;
      sh_th    <= '0;
      sh_n     <= HW'(1);
      act_freq <= '0;
      act_th   <= '0;
      act_n    <= HW'(1);
      pend     <= 1'b0;
      rej_q    <= 1'b0;
      hstep    <= '0;
      f_q      <= '0;
      h_q      <= '0;
    end else begin
      sh_freq  <= sh_freq_d;
      sh_th    <= sh_th_d;
      sh_n     <= sh_n_d;
      act_freq <= act_freq_d;
      act_th   <= act_th_d;
      act_n    <= act_n_d;
      pend     <= pend_d;
      rej_q    <= rej_d;
      hstep    <= hstep_d;
      f_q      <= f_d;
      h_q      <= h_d;
    end
  end

  assign fund_ph  = f_q;
  assign harm_ph  = h_q;
  assign ofs_ph   = act_th;
  assign harm_rej = rej_q;

  logic [PW-1:0] sync_ref;
  assign sync_ref = {{PAD{1'b0}}, act_n} * fund_ph;

  // R9
  harm_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    harm_ph == sync_ref);

  // R6
  harm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_n >= HW'(1)) && (act_n <= HW'(HMAX)));

  // R6
  harm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_harm && !harm_ok) |=> ($stable(sh_n) && harm_rej));

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(fund_ph) && $stable(harm_ph)));

endmodule

// File: rtl/harm_demod.sv
module harm_demod
  import harm_demod_pkg::*;
#(
  parameter int PW   = 32,
  parameter int SW   = 16,
  parameter int AW   = 6,
  parameter int HW   = HARM_W,
  parameter int HMAX = HARM_MAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_sample,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [PW-1:0]        cfg_wdata,
  output logic                 harm_rej,
  output logic                 out_valid,
  output logic signed [2*SW-1:0] out_x,
  output logic signed [2*SW-1:0] out_y,
  output logic signed [SW-1:0] ref_sine
);

  localparam int IW  = AW + 2;
  localparam int PRW = 2 * SW;
  localparam int NL  = 3;
  localparam int LX  = 0;
  localparam int LY  = 1;
  localparam int LF  = 2;
  localparam longint AMP = (longint'(1) << (SW - 1)) - 1;
  localparam logic [PW-1:0] QTR = {{(PW-1){1'b0}}, 1'b1} << (PW - 2);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign srst_n = rsync[1];

  logic [PW-1:0] fund_ph, harm_ph, ofs_ph;

  hd_phase_gen #(.PW(PW), .HW(HW), .HMAX(HMAX)) u_phase (
    .clk      (clk),
    .rst_n    (srst_n),
    .smp_en   (in_valid),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .fund_ph  (fund_ph),
    .harm_ph  (harm_ph),
    .ofs_ph   (ofs_ph),
    .harm_rej (harm_rej)
  );

  // stage 1: sample and table indices, stage 2: sine values, stage 3: products
  logic                 v1, v1_d, v2, v2_d, ov_d;
  logic signed [SW-1:0] smp1, smp1_d, smp2, smp2_d;
  logic [IW-1:0]        idx1 [NL];
  logic [IW-1:0]        idx1_d [NL];
  logic signed [SW-1:0] lut_o [NL];
  logic signed [SW-1:0] sv2 [NL];
  logic signed [SW-1:0] sv2_d [NL];
  logic signed [PRW-1:0] ox_d, oy_d;
  logic signed [SW-1:0]  os_d;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    hd_sine_lut #(.DW(SW), .AW(AW)) u_lut (
      .pidx (idx1[g]),
      .value(lut_o[g])
    );
  end

  always_comb begin
    v1_d   = in_valid;
    smp1_d = smp1;
    idx1_d = idx1;
    if (in_valid) begin
      smp1_d     = in_sample;
      idx1_d[LX] = IW'((harm_ph + ofs_ph) >> (PW - IW));
      idx1_d[LY] = IW'((harm_ph + ofs_ph + QTR) >> (PW - IW));
      idx1_d[LF] = IW'(fund_ph >> (PW - IW));
    end
    v2_d   = v1;
    smp2_d = smp2;
    sv2_d  = sv2;
    if (v1) begin
      smp2_d = smp1;
      sv2_d  = lut_o;
    end
    ov_d = v2;
    ox_d = out_x;
    oy_d = out_y;
    os_d = ref_sine;
    if (v2) begin
      ox_d = PRW'(smp2) * PRW'(sv2[LX]);
      oy_d = PRW'(smp2) * PRW'(sv2[LY]);
      os_d = sv2[LF];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      smp1      <= '0;
      smp2      <= '0;
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      ref_sine  <= '0;
      for (int i = 0; i < NL; i++) begin
        idx1[i] <= '0;
        sv2[i]  <= '0;
      end
    end else begin
      v1        <= v1_d;
      v2        <= v2_d;
      smp1      <= smp1_d;
      smp2      <= smp2_d;
      idx1      <= idx1_d;
      sv2       <= sv2_d;
      out_valid <= ov_d;
      out_x     <= ox_d;
      out_y     <= oy_d;
      ref_sine  <= os_d;
    end
  end

  logic signed [63:0] nrm_err;
  assign nrm_err = 64'(sv2[LX]) * 64'(sv2[LY]) * 0
                 + 64'(sv2[LX]) * 64'(sv2[LX])
                 + 64'(sv2[LY]) * 64'(sv2[LY]) - AMP * AMP;

  // R4
  quad_norm_chk: assert property (@(posedge clk) disable iff (!srst_n)
    v2 |-> ((nrm_err <= 2 * AMP) && (nrm_err >= -2 * AMP)));

  // R5
  out_lat_chk: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid |=> ##2 out_valid);

endmodule

// File: tb/harm_demod_bench.sv
module harm_demod_bench;

  localparam real PI = 3.14159265358979323846;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic               cfg_we = 1'b0;
  logic [1:0]         cfg_sel = '0;
  logic [31:0]        cfg_wdata = '0;
  logic               harm_rej, out_valid;
  logic signed [31:0] out_x, out_y;
  logic signed [15:0] ref_sine;

  harm_demod u_harm_demod (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .harm_rej(harm_rej), .out_valid(out_valid), .out_x(out_x),
    .out_y(out_y), .ref_sine(ref_sine)
  );

  // 20 ns period with a 1 ns time unit: 50 MHz
  always #10 clk = ~clk;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 0;

  // reference model state: active, shadow, pending
  logic [31:0] m_f = '0, m_fr = '0, m_th = '0, p_fr = '0, p_th = '0;
  int          m_n = 1, p_n = 1;
  bit          pend = 0;
  bit          m_rej = 0;

  typedef struct packed {
    logic [31:0] fr;
    logic [6:0]  n;
    logic [31:0] th;
    logic [15:0] smp;
    logic [3:0]  cnt;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0100_0000, 7'd1,  32'h0000_0000, 16'd1000,   4'd3},
    '{32'h0123_4567, 7'd3,  32'h1000_0000, 16'hF830,   4'd4},
    '{32'h0080_0000, 7'd99, 32'h0000_0001, 16'h7FFF,   4'd3},
    '{32'h0200_0000, 7'd7,  32'hC000_0000, 16'h8000,   4'd3},
    '{32'h3FFF_FFFF, 7'd1,  32'h4000_0000, 16'd12345,  4'd2}
  };

  function automatic logic signed [15:0] sref(input logic [31:0] p);
    real a;
    int  r;
    a = 32767.0 * $sin(2.0 * PI * real'(p[31:24]) / 256.0);
    r = (a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5);
    return 16'(r);
  endfunction

  task automatic chk(input string name, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", name, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    int n;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    case (sel)
      2'd0: begin p_fr = d; pend = 1; end
      2'd1: begin
        n = int'(d[6:0]);
        if (n >= 1 && n <= 99 && longint'(n) * longint'(p_fr) <= 64'h4000_0000) begin
          p_n = n; pend = 1; m_rej = 0;
        end else m_rej = 1;
      end
      2'd2: begin p_th = d; pend = 1; end
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic smp(input logic signed [15:0] s, input string tag);
    logic [31:0] rx, ry;
    longint ex, ey, es;
    rx = 32'(m_n) * m_f + m_th;
    ry = rx + 32'h4000_0000;
    ex = longint'(s) * longint'(sref(rx));
    ey = longint'(s) * longint'(sref(ry));
    es = longint'(sref(m_f));
    if (pend) begin
      m_fr = p_fr; m_n = p_n; m_th = p_th; pend = 0;
    end
    m_f = m_f + m_fr;
    @(negedge clk);
    in_valid = 1'b1; in_sample = s;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk({tag, " R5 valid pulse"}, longint'(out_valid), 1);
    chk({tag, " R3 X product"}, longint'(out_x), ex);
    chk({tag, " R4 Y product"}, longint'(out_y), ey);
    chk({tag, " R2 R8 fundamental sine"}, longint'(ref_sine), es);
    @(negedge clk);
    chk({tag, " R5 valid drops"}, longint'(out_valid), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 out_valid", longint'(out_valid), 0);
    chk("R1 out_x", longint'(out_x), 0);
    chk("R1 out_y", longint'(out_y), 0);
    chk("R1 ref_sine", longint'(ref_sine), 0);
    chk("R1 harm_rej", longint'(harm_rej), 0);

    // vector table; first sample of each entry still uses prior settings (R7)
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VECS[i].fr);
      wr(2'd1, 32'(VECS[i].n));
      wr(2'd2, VECS[i].th);
      for (int k = 0; k < int'(VECS[i].cnt); k++)
        smp($signed(VECS[i].smp), $sformatf("R7 vec%0d.%0d", i, k));
    end

    // R6: acceptance limit at exactly 2^30 and just above
    wr(2'd0, 32'h0400_0000);
    wr(2'd1, 32'd16);
    chk("R6 accept at limit", longint'(harm_rej), longint'(m_rej));
    chk("R6 accept flag clear", longint'(harm_rej), 0);
    wr(2'd1, 32'd17);
    chk("R6 reject above limit", longint'(harm_rej), 1);
    wr(2'd1, 32'd0);
    chk("R6 reject zero", longint'(harm_rej), 1);
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'd100);
    chk("R6 reject 100", longint'(harm_rej), 1);
    smp(16'sd3000, "R6 kept N");
    smp(16'sd3000, "R6 kept N next");
    wr(2'd1, 32'd5);
    chk("R6 later accept clears", longint'(harm_rej), 0);

    // R9: run at an odd step, then change N mid-stream
    wr(2'd0, 32'h0567_89AB);
    wr(2'd1, 32'd2);
    for (int k = 0; k < 4; k++) smp(16'sd2500, "R9 pre");
    wr(2'd1, 32'd9);
    for (int k = 0; k < 3; k++) smp(-16'sd1500, "R9 post");

    // R8: offset change alone must not move the fundamental sine
    wr(2'd2, 32'h7654_3210);
    for (int k = 0; k < 2; k++) smp(16'sd900, "R8 offset");

    // R10: select 3 is ignored
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R10 harm_rej unchanged", longint'(harm_rej), 0);
    for (int k = 0; k < 2; k++) smp(16'sd700, "R10 unused select");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule